// File: doc/BRIEF.md
# Quadrature Channel Input Filter

This block conditions the raw, asynchronous signals coming from a rotary quadrature encoder before any decoding logic sees them. The two phase channels pass through a two-flop synchronizer and a change detector, and then share one stability counter. A change on either channel restarts the count. Once both channels have held still for the configured number of clock cycles, their synchronized values are copied together into the output register. The counter then parks itself and stays parked until the next change.

An active-low origin push button is conditioned by a second, independent copy of the same filter. That copy has its own, usually much longer, stability period. A decoder downstream consumes the three clean outputs. It never sees bounce, and it never sees one channel update without the other. The stability periods are parameters given in clock cycles.

Top module: `qif_top`

## Requirements
- R1: While `rst_n` is low, and after its release until a filtered value loads, `a_clean`, `b_clean` and `origin_n_clean` are all 0.
- R2: If the phase inputs take a new value that is first sampled at clock edge k and then held, the new value appears on `a_clean`/`b_clean` right after edge k+AB_HOLD+2 and not before.
- R3: A change on either phase input restarts the shared stability count. Both phase outputs therefore load together, AB_HOLD+2 edges after the last change of either input.
- R4: A pulse on a phase input that returns to its former level in fewer than AB_HOLD clock cycles never shows on the phase outputs.
- R5: After a load the filter goes idle, and its outputs stay constant for as long as its inputs do not change.
- R6: The origin input is filtered with its own period. A held new value first sampled at edge k appears on `origin_n_clean` right after edge k+ORG_HOLD+2 and not before.
- R7: Activity on the phase inputs has no effect on `origin_n_clean`, and activity on the origin input has no effect on the phase outputs.
- R8: A filtered output changes only at the end of a running stability count, never while its filter is idle.
- R9: A pulse on the origin input shorter than ORG_HOLD clock cycles never shows on `origin_n_clean`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder phase A, asynchronous |
| enc_b | input | 1 | Raw encoder phase B, asynchronous |
| origin_n | input | 1 | Raw active-low origin button, asynchronous |
| a_clean | output | 1 | Filtered phase A |
| b_clean | output | 1 | Filtered phase B |
| origin_n_clean | output | 1 | Filtered origin button |

## Verification
The bound checker watches properties that hold on every clock. A filtered output may change only when its counter was running in the cycle before. The change must leave the filter idle. The counter must start without touching the output. These properties cover R5 and R8 for both filters. The scenarios cover what a per-cycle property cannot. They measure the exact latency edge by edge. They show that a mid-count change on the other channel pushes the update back, and that short pulses vanish. They also show that each filter ignores the other's inputs.

// File: rtl/qif_pkg.sv
package qif_pkg;
    // Width of a counter that must hold values 0..hold inclusive.
    function automatic int cnt_width(input int hold);
        return (hold < 1) ? 1 : $clog2(hold + 1);
    endfunction
endpackage

// File: rtl/qif_sync.sv
module qif_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/qif_filter.sv
module qif_filter #(
    parameter int N    = 2,
    parameter int HOLD = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    output logic [N-1:0] clean_o,
    output logic         busy_o
);
    localparam int            CW     = qif_pkg::cnt_width(HOLD);
    localparam logic [CW-1:0] IDLE_C = CW'(HOLD);
    localparam logic [CW-1:0] LAST_C = CW'(HOLD - 1);

    typedef struct packed {
        logic [N-1:0]  prev;
        logic [N-1:0]  clean;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t        filt_d, filt_q;
    logic [N-1:0] chg;
    logic         any_chg;

    for (genvar i = 0; i < N; i++) begin : g_chg
        assign chg[i] = sync_i[i] ^ filt_q.prev[i];
    end
    assign any_chg = |chg;

    always_comb begin
        filt_d      = filt_q;
        filt_d.prev = sync_i;
        if (any_chg) begin
            filt_d.cnt = '0;
        end else if (filt_q.cnt != IDLE_C) begin
            if (filt_q.cnt == LAST_C) begin
                filt_d.clean = sync_i;
                filt_d.cnt   = IDLE_C;
            end else begin
                filt_d.cnt = filt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q.prev  <= '0;
            filt_q.clean <= '0;
            filt_q.cnt   <= IDLE_C;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign clean_o = filt_q.clean;
    assign busy_o  = (filt_q.cnt != IDLE_C);
endmodule

// File: rtl/qif_top.sv
module qif_top #(
    parameter int AB_HOLD  = 50000,
    parameter int ORG_HOLD = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    input  logic origin_n,
    output logic a_clean,
    output logic b_clean,
    output logic origin_n_clean
);
    logic [1:0] ab_sync;
    logic [1:0] ab_clean;
    logic [0:0] org_sync;
    logic [0:0] org_clean;
    logic       ab_busy;
    logic       org_busy;

    qif_sync #(.N(2)) u_ab_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({enc_b, enc_a}), .sync_o(ab_sync)
    );

    qif_filter #(.N(2), .HOLD(AB_HOLD)) u_ab_filt (
        .clk(clk), .rst_n(rst_n), .sync_i(ab_sync),
        .clean_o(ab_clean), .busy_o(ab_busy)
    );

    qif_sync #(.N(1)) u_org_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(origin_n), .sync_o(org_sync)
    );

    qif_filter #(.N(1), .HOLD(ORG_HOLD)) u_org_filt (
        .clk(clk), .rst_n(rst_n), .sync_i(org_sync),
        .clean_o(org_clean), .busy_o(org_busy)
    );

    assign a_clean        = ab_clean[0];
    assign b_clean        = ab_clean[1];
    assign origin_n_clean = org_clean[0];
endmodule

// File: rtl/qif_checker.sv
module qif_checker (
    input logic clk,
    input logic rst_n,
    input logic a_clean,
    input logic b_clean,
    input logic origin_n_clean,
    input logic ab_busy,
    input logic org_busy
);
    AST_AB_LOAD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ({a_clean, b_clean} != $past({a_clean, b_clean})) |-> $past(ab_busy)); // R8
    AST_ORG_LOAD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (origin_n_clean != $past(origin_n_clean)) |-> $past(org_busy)); // R8
    AST_AB_IDLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ({a_clean, b_clean} != $past({a_clean, b_clean})) |-> !ab_busy); // R5
    AST_ORG_IDLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (origin_n_clean != $past(origin_n_clean)) |-> !org_busy); // R5
    AST_AB_START_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ab_busy) |-> $stable({a_clean, b_clean})); // R8
endmodule

bind qif_top qif_checker u_chk (
    .clk(clk), .rst_n(rst_n), .a_clean(a_clean), .b_clean(b_clean),
    .origin_n_clean(origin_n_clean), .ab_busy(ab_busy), .org_busy(org_busy)
);

// File: tb/tb_qif_top.sv
module tb_qif_top;
    localparam int ABH = 8;
    localparam int ORH = 20;

    logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, origin_n = 0;
    logic a_clean, b_clean, origin_n_clean;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    qif_top #(.AB_HOLD(ABH), .ORG_HOLD(ORH)) dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .origin_n(origin_n),
        .a_clean(a_clean), .b_clean(b_clean), .origin_n_clean(origin_n_clean)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk("R1 a", a_clean, 0); chk("R1 b", b_clean, 0); chk("R1 org", origin_n_clean, 0);
        rst_n = 1;
        negs(ABH + 5);
        chk("R1 a after release", a_clean, 0); chk("R1 org after release", origin_n_clean, 0);
    endtask

    // R2: exact latency; R7: origin untouched
    task automatic t_latency();
        @(negedge clk); enc_a = 1;
        negs(ABH + 2);
        chk("R2 a not early", a_clean, 0);
        negs(1);
        chk("R2 a on time", a_clean, 1); chk("R2 b held", b_clean, 0);
        chk("R7 org unaffected", origin_n_clean, 0);
        negs(30);
        chk("R5 a holds", a_clean, 1); chk("R5 b holds", b_clean, 0);
    endtask

    // R3: mid-count change on B restarts count; both load together
    task automatic t_restart();
        @(negedge clk); enc_a = 0;
        negs(5);
        enc_b = 1;
        negs(ABH + 2);
        chk("R3 a delayed", a_clean, 1); chk("R3 b not early", b_clean, 0);
        negs(1);
        chk("R3 a loads", a_clean, 0); chk("R3 b loads", b_clean, 1);
    endtask

    // R4: short pulse on A invisible
    task automatic t_glitch();
        @(negedge clk); enc_a = 1;
        negs(ABH - 1);
        enc_a = 0;
        for (int i = 0; i < ABH + 6; i++) begin
            negs(1);
            chk("R4 a glitch", a_clean, 0);
        end
        chk("R4 b", b_clean, 1);
    endtask

    // R6 latency, R7 phase outputs unaffected, R9 short origin pulse
    task automatic t_origin();
        @(negedge clk); origin_n = 1;
        negs(ORH + 2);
        chk("R6 org not early", origin_n_clean, 0);
        chk("R7 a unaffected", a_clean, 0); chk("R7 b unaffected", b_clean, 1);
        negs(1);
        chk("R6 org on time", origin_n_clean, 1);
        origin_n = 0;
        negs(ORH - 2);
        origin_n = 1;
        for (int i = 0; i < ORH + 6; i++) begin
            negs(1);
            chk("R9 org glitch", origin_n_clean, 1);
        end
    endtask

    initial begin
        fork
            begin
                t_reset(); t_latency(); t_restart(); t_glitch(); t_origin();
            end
            begin
                negs(20000);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule